// File: doc/BRIEF.md
# GF(16) Recombination Key Inverter

This unit derives, on chip, the 2×2 matrix that recombines two surviving nibble streams into the original byte stream. It receives all four 8-bit dispersal key vectors together with the numbers of two intact sinks. The two selected key vectors become the rows of a 2×2 matrix B, and the unit returns T = B⁻¹ over GF(16) with reduction polynomial x⁴+x+1 (binary 10011). The host therefore never has to invert the keys itself.

The computation is sequential and uses a single shared GF(16) multiplier. The unit first forms the determinant with two products. It takes the reciprocal by raising the determinant to the power 14, one square or multiply per cycle. It then scales the adjugate with four more products. A `start` pulse launches a run, and `done` pulses once when the four result nibbles and the `singular` flag are valid. A zero determinant or two identical sink numbers make the matrix singular. In that case the flag is raised, the result is zero and the usual `done` pulse still follows.

Top module: `gf16_key_inverter`

## Requirements
- R1: After a run whose `singular` is 0, the product T·B is the identity over GF(16). Row 0 of B is the key of the lower-numbered selected sink and row 1 is the key of the other. Sink i occupies `keys[8i+7:8i]`, with column 0 in the low nibble and column 1 in the high nibble. T is presented row-major as `t00`, `t01`, `t10`, `t11`.
- R2: Exchanging the values on `sink_a` and `sink_b` gives the same result.
- R3: All products are reduced modulo binary 10011. A run with row 0 = 0x01 and row 1 = 0x21 yields T = [[1,0],[9,9]].
- R4: When the determinant b00·b11 ⊕ b01·b10 is zero, `singular` is 1, all four result nibbles are 0, and `done` still pulses.
- R5: When `sink_a` equals `sink_b`, `singular` is 1 and all four result nibbles are 0, whatever the keys.
- R6: `done` is high for exactly one cycle. It rises 14 clock edges after the edge at which `start` was accepted (2·SYM_W+6 in general), for singular and non-singular runs alike.
- R7: `busy` is high from the edge that accepts `start` until the edge that raises `done`. A `start` that arrives while `busy` is high is ignored: it produces no extra `done` and does not change the result.
- R8: Between `done` pulses, `singular` and the four result nibbles hold their values, even if `keys`, `sink_a` or `sink_b` change.
- R9: After reset, `busy`, `done`, `singular` and all result nibbles are 0.
- R10: The reciprocal of 2 is 9. Row 0 = 0x02 and row 1 = 0x10 give T = [[9,0],[0,1]].
- R11: Keys and sink numbers are captured at the edge that accepts `start`. Changes to them during a run have no effect on that run's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a run; accepted only when idle |
| keys | input | NUM_SINKS·2·SYM_W | All key vectors, sink i at slice i |
| sink_a | input | clog2(NUM_SINKS) | First intact sink number |
| sink_b | input | clog2(NUM_SINKS) | Second intact sink number |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle strobe: result valid |
| singular | output | 1 | No inverse exists for the selection |
| t00 | output | SYM_W | Result row 0, column 0 |
| t01 | output | SYM_W | Result row 0, column 1 |
| t10 | output | SYM_W | Result row 1, column 0 |
| t11 | output | SYM_W | Result row 1, column 1 |

## Verification
The bench builds the unit with its defaults: 4-bit symbols, four sinks and reduction polynomial 10011. With these values every ordered pair of sink numbers can be applied, including equal pairs. Random keys also reach every non-zero determinant, so the full reciprocal path is exercised over all fifteen field elements, alongside the zero-determinant and equal-sink singular paths. The fixed 14-cycle latency stays short enough that start pulses can be placed in every phase of a run, which covers the rule that starts are ignored while busy.

// File: rtl/gfi_pkg.sv
package gfi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DET0,
    ST_DET1,
    ST_EXPO,
    ST_SCALE
  } gfi_state_e;

  // Cycles from the accepting edge to the edge that raises done
  function automatic int gfi_latency(input int sym_w);
    return 2 * sym_w + 6;
  endfunction

endpackage

// File: rtl/gfi_mul.sv
// Combinational GF(2^W) multiplier: one shift/add/reduce stage per bit of b
module gfi_mul #(
  parameter int              SYM_W = 4,
  parameter logic [SYM_W:0]  POLY  = 5'b10011
) (
  input  logic [SYM_W-1:0] a,
  input  logic [SYM_W-1:0] b,
  output logic [SYM_W-1:0] p
);

  localparam logic [SYM_W-1:0] RED = POLY[SYM_W-1:0];

  logic [SYM_W-1:0] acc [SYM_W+1];

  assign acc[0] = '0;

  for (genvar g = 0; g < SYM_W; g++) begin : g_stage
    logic [SYM_W:0] sh;
    assign sh = {acc[g], 1'b0} ^ {1'b0, (a & {SYM_W{b[SYM_W-1-g]}})};
    assign acc[g+1] = sh[SYM_W-1:0] ^ (RED & {SYM_W{sh[SYM_W]}});
  end

  assign p = acc[SYM_W];

endmodule

// File: rtl/gfi_row_pick.sv
// Selects the two key rows, lower sink number first
module gfi_row_pick #(
  parameter int SYM_W     = 4,
  parameter int NUM_SINKS = 4,
  localparam int IDX_W    = $clog2(NUM_SINKS),
  localparam int KEY_W    = 2 * SYM_W
) (
  input  logic [NUM_SINKS*KEY_W-1:0] keys,
  input  logic [IDX_W-1:0]           sel_a,
  input  logic [IDX_W-1:0]           sel_b,
  output logic [SYM_W-1:0]           b00,
  output logic [SYM_W-1:0]           b01,
  output logic [SYM_W-1:0]           b10,
  output logic [SYM_W-1:0]           b11,
  output logic                       same
);

  logic [KEY_W-1:0] kv [NUM_SINKS];
  logic [IDX_W-1:0] lo_idx;
  logic [IDX_W-1:0] hi_idx;
  logic [KEY_W-1:0] row0;
  logic [KEY_W-1:0] row1;

  for (genvar g = 0; g < NUM_SINKS; g++) begin : g_slice
    assign kv[g] = keys[g*KEY_W +: KEY_W];
  end

  always_comb begin
    if (sel_a < sel_b) begin
      lo_idx = sel_a;
      hi_idx = sel_b;
    end else begin
      lo_idx = sel_b;
      hi_idx = sel_a;
    end
  end

  assign row0 = kv[lo_idx];
  assign row1 = kv[hi_idx];
  assign b00  = row0[SYM_W-1:0];
  assign b01  = row0[KEY_W-1:SYM_W];
  assign b10  = row1[SYM_W-1:0];
  assign b11  = row1[KEY_W-1:SYM_W];
  assign same = (sel_a == sel_b);

endmodule

// File: rtl/gfi_ctrl.sv
// Sequencer: determinant, exponentiation, scaling
module gfi_ctrl #(
  parameter int  SYM_W = 4,
  localparam int CNT_W = $clog2(2 * SYM_W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output gfi_pkg::gfi_state_e   state_o,
  output logic [CNT_W-1:0]      step_o,
  output logic                  load_o,
  output logic                  last_o,
  output logic                  busy_o
);

  import gfi_pkg::*;

  localparam logic [CNT_W-1:0] EXP_LAST = CNT_W'(2 * SYM_W - 1);
  localparam logic [CNT_W-1:0] SC_LAST  = CNT_W'(3);

  gfi_state_e       state_q, state_d;
  logic [CNT_W-1:0] step_q, step_d;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_DET0;
          step_d  = '0;
        end
      end
      ST_DET0: state_d = ST_DET1;
      ST_DET1: begin
        state_d = ST_EXPO;
        step_d  = '0;
      end
      ST_EXPO: begin
        if (step_q == EXP_LAST) begin
          state_d = ST_SCALE;
          step_d  = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      ST_SCALE: begin
        if (step_q == SC_LAST) begin
          state_d = ST_IDLE;
          step_d  = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        step_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign state_o = state_q;
  assign step_o  = step_q;
  assign load_o  = (state_q == ST_IDLE) && start;
  assign last_o  = (state_q == ST_SCALE) && (step_q == SC_LAST);
  assign busy_o  = (state_q != ST_IDLE);

endmodule

// File: rtl/gf16_key_inverter.sv
// On-chip 2x2 recombination matrix inverter over GF(2^SYM_W)
module gf16_key_inverter #(
  parameter int              SYM_W     = 4,
  parameter int              NUM_SINKS = 4,
  parameter logic [SYM_W:0]  POLY      = 5'b10011,
  localparam int             IDX_W     = $clog2(NUM_SINKS),
  localparam int             KEY_W     = 2 * SYM_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [NUM_SINKS*KEY_W-1:0] keys,
  input  logic [IDX_W-1:0]           sink_a,
  input  logic [IDX_W-1:0]           sink_b,
  output logic                       busy,
  output logic                       done,
  output logic                       singular,
  output logic [SYM_W-1:0]           t00,
  output logic [SYM_W-1:0]           t01,
  output logic [SYM_W-1:0]           t10,
  output logic [SYM_W-1:0]           t11
);

  import gfi_pkg::*;

  localparam int               CNT_W   = $clog2(2 * SYM_W);
  localparam logic [SYM_W-1:0] EXP_VAL = SYM_W'((1 << SYM_W) - 2);
  localparam logic [SYM_W-1:0] ONE     = SYM_W'(1);

  gfi_state_e       state;
  logic [CNT_W-1:0] step;
  logic             load;
  logic             last;

  logic [SYM_W-1:0] pk00, pk01, pk10, pk11;
  logic             pk_same;

  logic [SYM_W-1:0] op_a, op_b, prod, d_val;

  logic [SYM_W-1:0] m00_q, m01_q, m10_q, m11_q;
  logic [SYM_W-1:0] m00_d, m01_d, m10_d, m11_d;
  logic             same_q, same_d;
  logic [SYM_W-1:0] acc_q, acc_d;
  logic [SYM_W-1:0] r_q, r_d;
  logic [SYM_W-1:0] base_q, base_d;
  logic             sing_q, sing_d;
  logic [SYM_W-1:0] s0_q, s0_d, s1_q, s1_d, s2_q, s2_d;
  logic [SYM_W-1:0] t00_q, t00_d, t01_q, t01_d, t10_q, t10_d, t11_q, t11_d;
  logic             singular_q, singular_d;
  logic             done_q, done_d;

  gfi_ctrl #(.SYM_W(SYM_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .state_o (state),
    .step_o  (step),
    .load_o  (load),
    .last_o  (last),
    .busy_o  (busy)
  );

  gfi_row_pick #(.SYM_W(SYM_W), .NUM_SINKS(NUM_SINKS)) u_pick (
    .keys  (keys),
    .sel_a (sink_a),
    .sel_b (sink_b),
    .b00   (pk00),
    .b01   (pk01),
    .b10   (pk10),
    .b11   (pk11),
    .same  (pk_same)
  );

  gfi_mul #(.SYM_W(SYM_W), .POLY(POLY)) u_mul (
    .a (op_a),
    .b (op_b),
    .p (prod)
  );

  // Operand steering for the shared multiplier
  always_comb begin
    op_a = '0;
    op_b = '0;
    case (state)
      ST_DET0: begin
        op_a = m00_q;
        op_b = m11_q;
      end
      ST_DET1: begin
        op_a = m01_q;
        op_b = m10_q;
      end
      ST_EXPO: begin
        if (!step[0]) begin
          op_a = r_q;
          op_b = base_q;
        end else begin
          op_a = base_q;
          op_b = base_q;
        end
      end
      ST_SCALE: begin
        op_a = r_q;
        case (step[1:0])
          2'd0:    op_b = m11_q;
          2'd1:    op_b = m01_q;
          2'd2:    op_b = m10_q;
          default: op_b = m00_q;
        endcase
      end
      default: ;
    endcase
  end

  assign d_val = acc_q ^ prod;

  // Next-state of the datapath
  always_comb begin
    m00_d      = m00_q;
    m01_d      = m01_q;
    m10_d      = m10_q;
    m11_d      = m11_q;
    same_d     = same_q;
    acc_d      = acc_q;
    r_d        = r_q;
    base_d     = base_q;
    sing_d     = sing_q;
    s0_d       = s0_q;
    s1_d       = s1_q;
    s2_d       = s2_q;
    t00_d      = t00_q;
    t01_d      = t01_q;
    t10_d      = t10_q;
    t11_d      = t11_q;
    singular_d = singular_q;
    done_d     = last;

    if (load) begin
      m00_d  = pk00;
      m01_d  = pk01;
      m10_d  = pk10;
      m11_d  = pk11;
      same_d = pk_same;
    end

    case (state)
      ST_DET0: acc_d = prod;
      ST_DET1: begin
        base_d = d_val;
        r_d    = ONE;
        sing_d = same_q | (d_val == '0);
      end
      ST_EXPO: begin
        if (!step[0]) begin
          if (EXP_VAL[step[CNT_W-1:1]]) r_d = prod;
        end else begin
          base_d = prod;
        end
      end
      ST_SCALE: begin
        if (last) begin
          singular_d = sing_q;
          if (sing_q) begin
            t00_d = '0;
            t01_d = '0;
            t10_d = '0;
            t11_d = '0;
          end else begin
            t00_d = s0_q;
            t01_d = s1_q;
            t10_d = s2_q;
            t11_d = prod;
          end
        end else begin
          case (step[1:0])
            2'd0:    s0_d = prod;
            2'd1:    s1_d = prod;
            default: s2_d = prod;
          endcase
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m00_q      <= '0;
      m01_q      <= '0;
      m10_q      <= '0;
      m11_q      <= '0;
      same_q     <= 1'b0;
      acc_q      <= '0;
      r_q        <= '0;
      base_q     <= '0;
      sing_q     <= 1'b0;
      s0_q       <= '0;
      s1_q       <= '0;
      s2_q       <= '0;
      t00_q      <= '0;
      t01_q      <= '0;
      t10_q      <= '0;
      t11_q      <= '0;
      singular_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      m00_q      <= m00_d;
      m01_q      <= m01_d;
      m10_q      <= m10_d;
      m11_q      <= m11_d;
      same_q     <= same_d;
      acc_q      <= acc_d;
      r_q        <= r_d;
      base_q     <= base_d;
      sing_q     <= sing_d;
      s0_q       <= s0_d;
      s1_q       <= s1_d;
      s2_q       <= s2_d;
      t00_q      <= t00_d;
      t01_q      <= t01_d;
      t10_q      <= t10_d;
      t11_q      <= t11_d;
      singular_q <= singular_d;
      done_q     <= done_d;
    end
  end

  assign done     = done_q;
  assign singular = singular_q;
  assign t00      = t00_q;
  assign t01      = t01_q;
  assign t10      = t10_q;
  assign t11      = t11_q;

endmodule

// File: rtl/gf16_key_inverter_checker.sv
module gf16_key_inverter_checker #(
  parameter int SYM_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             singular,
  input logic [SYM_W-1:0] t00,
  input logic [SYM_W-1:0] t01,
  input logic [SYM_W-1:0] t10,
  input logic [SYM_W-1:0] t11
);

  localparam int LAT = gfi_pkg::gfi_latency(SYM_W);

  logic        run_q;
  logic [15:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (done) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_done_on_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_q && cnt_q == 16'(LAT)));

  assert_done_not_late_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == 16'(LAT)) |-> done);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_ends_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_singular_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && singular) |-> (t00 == '0 && t01 == '0 && t10 == '0 && t11 == '0));

  assert_result_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(t00) && $stable(t01) && $stable(t10) && $stable(t11)
               && $stable(singular)));

endmodule

bind gf16_key_inverter gf16_key_inverter_checker #(.SYM_W(SYM_W)) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .singular (singular),
  .t00      (t00),
  .t01      (t01),
  .t10      (t10),
  .t11      (t11)
);

// File: tb/gf16_key_inverter_bench.sv
module gf16_key_inverter_bench;

  localparam int LAT = 14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] keys;
  logic [1:0]  sink_a, sink_b;
  logic        busy, done, singular;
  logic [3:0]  t00, t01, t10, t11;

  int checks   = 0;
  int failures = 0;

  always #4 clk = ~clk;

  gf16_key_inverter u_gf16_key_inverter (
    .clk(clk), .rst_n(rst_n), .start(start), .keys(keys),
    .sink_a(sink_a), .sink_b(sink_b), .busy(busy), .done(done),
    .singular(singular), .t00(t00), .t01(t01), .t10(t10), .t11(t11)
  );

  // ---------------- behavioural field arithmetic ----------------
  function automatic logic [3:0] gm(input logic [3:0] a, input logic [3:0] b);
    int p = 0;
    for (int i = 0; i < 4; i++) if (b[i]) p = p ^ (int'(a) << i);
    for (int k = 6; k >= 4; k--) if (p[k]) p = p ^ (32'h13 << (k - 4));
    return p[3:0];
  endfunction

  function automatic logic [3:0] ginv(input logic [3:0] d);
    for (int c = 1; c < 16; c++) if (gm(d, 4'(c)) == 4'd1) return 4'(c);
    return 4'd0;
  endfunction

  // returns {singular, t00, t01, t10, t11}
  function automatic logic [16:0] ref_calc(input logic [31:0] k, input logic [1:0] a,
                                           input logic [1:0] b);
    int lo = (a < b) ? a : b;
    int hi = (a < b) ? b : a;
    logic [7:0] r0 = k[lo*8 +: 8];
    logic [7:0] r1 = k[hi*8 +: 8];
    logic [3:0] det = gm(r0[3:0], r1[7:4]) ^ gm(r0[7:4], r1[3:0]);
    logic [3:0] iv;
    if (a == b || det == 4'd0) return 17'h10000;
    iv = ginv(det);
    return {1'b0, gm(iv, r1[7:4]), gm(iv, r0[7:4]), gm(iv, r1[3:0]), gm(iv, r0[3:0])};
  endfunction

  // ---------------- cycle-by-cycle reference model ----------------
  logic        m_busy, m_done;
  logic [16:0] m_res, m_pend;
  int          m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0;
      m_done <= 1'b0;
      m_res  <= '0;
      m_pend <= '0;
      m_cnt  <= 0;
    end else if (m_cnt > 0) begin
      m_cnt <= m_cnt - 1;
      if (m_cnt == 1) begin
        m_busy <= 1'b0;
        m_done <= 1'b1;
        m_res  <= m_pend;
      end else begin
        m_done <= 1'b0;
      end
    end else begin
      m_done <= 1'b0;
      if (start) begin
        m_busy <= 1'b1;
        m_cnt  <= LAT;
        m_pend <= ref_calc(keys, sink_a, sink_b);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [16:0] dut_res;
  assign dut_res = {singular, t00, t01, t10, t11};

  always @(negedge clk) begin
    if (rst_n) begin
      check("R7 busy vs model", 32'(busy), 32'(m_busy));
      check("R6 done vs model", 32'(done), 32'(m_done));
      check(m_done ? "R1 result vs model" : "R8 held result vs model",
            32'(dut_res), 32'(m_res));
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_case(input logic [31:0] k, input logic [1:0] a, input logic [1:0] b,
                          output logic [16:0] got);
    int guard;
    @(negedge clk);
    keys = k; sink_a = a; sink_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 40) begin
      @(negedge clk);
      guard++;
    end
    if (!done) check("R6 done never rose", 32'(done), 32'd1);
    got = dut_res;
  endtask

  // T*B == I check for R1
  task automatic check_identity(input logic [31:0] k, input logic [1:0] a, input logic [1:0] b,
                                input logic [16:0] got);
    int lo = (a < b) ? a : b;
    int hi = (a < b) ? b : a;
    logic [7:0] r0 = k[lo*8 +: 8];
    logic [7:0] r1 = k[hi*8 +: 8];
    logic [3:0] x00 = got[15:12], x01 = got[11:8], x10 = got[7:4], x11 = got[3:0];
    logic [15:0] idm;
    idm[15:12] = gm(x00, r0[3:0]) ^ gm(x01, r1[3:0]);
    idm[11:8]  = gm(x00, r0[7:4]) ^ gm(x01, r1[7:4]);
    idm[7:4]   = gm(x10, r0[3:0]) ^ gm(x11, r1[3:0]);
    idm[3:0]   = gm(x10, r0[7:4]) ^ gm(x11, r1[7:4]);
    check("R1 T*B identity", 32'(idm), 32'h1001);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [16:0] got, got2;
    logic [31:0] k;
    int          done_seen;
    rst_n = 1'b0; start = 1'b0; keys = '0; sink_a = '0; sink_b = '0;
    repeat (3) @(negedge clk);
    check("R9 reset busy", 32'(busy), 32'd0);
    check("R9 reset done", 32'(done), 32'd0);
    check("R9 reset result", 32'(dut_res), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: rows 0x01 / 0x21 -> [[1,0],[9,9]]
    run_case(32'h0000_2101, 2'd0, 2'd1, got);
    check("R3 example inverse", 32'(got), 32'h0_1099);

    // R10: reciprocal of 2
    run_case(32'h1000_0200, 2'd1, 2'd3, got);
    check("R10 inverse of 2", 32'(got), 32'h0_9001);

    // R2: swapped order
    k = 32'h7A3C_51E9;
    run_case(k, 2'd1, 2'd3, got);
    run_case(k, 2'd3, 2'd1, got2);
    check("R2 swap invariance", 32'(got2), 32'(got));
    check("R2 swap vs reference", 32'(got2), 32'(ref_calc(k, 2'd1, 2'd3)));

    // R4: zero determinant
    run_case(32'h3500_0035, 2'd0, 2'd3, got);
    check("R4 singular on zero determinant", 32'(got), 32'h1_0000);

    // R5: equal sink numbers
    run_case(32'h0000_2101, 2'd2, 2'd2, got);
    check("R5 singular on equal sinks", 32'(got), 32'h1_0000);

    // R8: hold while inputs move without start
    run_case(32'h0000_2101, 2'd0, 2'd1, got);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      keys = 32'hDEAD_BEEF ^ 32'(i); sink_a = 2'(i); sink_b = 2'(i + 1);
    end
    check("R8 result held", 32'(dut_res), 32'h0_1099);

    // R7 + R11: start while busy and key changes mid-run are ignored
    @(negedge clk);
    keys = 32'h0000_0200; sink_a = 2'd0; sink_b = 2'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    keys = 32'h0000_2101;
    repeat (3) @(negedge clk);
    start = 1'b1; sink_b = 2'd0;
    @(negedge clk);
    start = 1'b0;
    done_seen = 0;
    for (int i = 0; i < 30; i++) begin
      if (done) begin
        done_seen++;
        check("R11 result from captured keys", 32'(dut_res), 32'(ref_calc(32'h0000_0200, 2'd0, 2'd1)));
      end
      @(negedge clk);
    end
    check("R7 single done for ignored start", 32'(done_seen), 32'd1);

    // R1: random keys over all sink pairs
    for (int n = 0; n < 64; n++) begin
      logic [1:0] a = 2'(n % 4);
      logic [1:0] b = 2'((n / 4) % 4);
      k = $urandom;
      run_case(k, a, b, got);
      check("R1 random vs reference", 32'(got), 32'(ref_calc(k, a, b)));
      if (!got[16]) check_identity(k, a, b, got);
    end

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule